// File: doc/BRIEF.md
# Adapter Board Control and Parity Error Capture

This block holds the control/status word and the parity-error capture registers of a bus-attached network adapter. A host reaches three 16-bit registers through a simple register port (a select, a write strobe, write data and a combinational read-back). The control word drives the network controller's reset and channel-attention inputs, releases the interface from loopback, turns on the auxiliary memory bus, selects the RAM part size and gates the two interrupt sources.

The memory subsystem reports a parity failure with a one-cycle strobe that carries the failing 20-bit address, the source of the access and the byte lane that failed. The first such failure is latched together with its address, source and lane, and the capture stays frozen until the host acknowledges it through a write-one-to-clear bit. A host interrupt is raised from the controller's own interrupt request and from a pending parity error, each under its own enable. The upper four bits of the memory base address come from board straps and are visible, read-only, in the low bits of the control word.

Top module: `board_ctl_unit`

## Requirements
- R1: Bit 15 of the control word (select 0) drives `ctl_reset` from the clock edge after the write; writing 0 there releases it.
- R2: Control-word bits 14, 13, 5 and 4 drive `on_air`, `ctl_attn`, `p2_en` and `ram_256k` respectively from the edge after the write, and bits 15..11, 5 and 4 read back as written; setting and then clearing bit 13 gives a one-write-long attention pulse.
- R3: Control-word bits 3:0 read the `base_strap` input; writes to bits 10, 9, 8, 7, 6 and 3:0 of the control word have no effect on anything read back.
- R4: Control-word bit 8 shows `ctl_irq` as sampled on the previous clock edge.
- R5: A `par_err` strobe while no error is pending sets control-word bit 9 at the next edge and captures address bits 19:16 into parity-control bits 3:0, address bits 15:0 into the low-address register (select 2), `par_src` into parity-control bit 7 and `par_lane` into parity-control bit 6.
- R6: While the parity-error flag is set, further strobes change neither the flag nor the captured address, source or lane.
- R7: Writing a 1 to parity-control bit 8 (select 1) clears the parity-error flag; bit 8 always reads 0, and a write to select 1 with bit 8 at 0 changes nothing.
- R8: A strobe arriving in the same cycle as an acknowledge is captured: the flag stays set and the new address, source and lane replace the old ones.
- R9: `host_irq` is high exactly when (control bit 8 and control bit 12) or (control bit 9 and control bit 11) are both set, evaluated on the registered state.
- R10: Select 0 reads the control word, select 1 the parity-control register, select 2 the captured low address, select 3 reads zero; writes to selects 2 and 3 are ignored.
- R11: After reset every output is low, the parity flag and captures are zero, and the control word reads only the strap bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 parity control, 2 low address, 3 unused |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| base_strap | input | 4 | Memory base address bits 20:17 from straps |
| ctl_irq | input | 1 | Interrupt request from the network controller |
| par_err | input | 1 | One-cycle parity-error strobe |
| par_addr | input | 20 | Failing address with the strobe |
| par_src | input | 1 | Source of the failing access |
| par_lane | input | 1 | Byte lane that failed |
| ctl_reset | output | 1 | Reset to the controller |
| ctl_attn | output | 1 | Channel attention to the controller |
| on_air | output | 1 | Loopback release |
| p2_en | output | 1 | Auxiliary memory bus enable |
| ram_256k | output | 1 | RAM part size select |
| host_irq | output | 1 | Interrupt to the host |

## Verification
Directed sequences drive all-ones and all-zero control words, an attention pulse, and strobes of distinct addresses and lanes so that capture, hold under a second error, acknowledge, and acknowledge colliding with a new error give different captured values. Interrupt checks toggle the controller request under each enable combination, which separates the two interrupt terms. A long stretch of mixed writes, strobes and requests then runs against the cycle model, exposing lost or extra updates that the directed cases could mask.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_PARCTL = 2'd1,
    SEL_PARLO  = 2'd2,
    SEL_NONE   = 2'd3
  } bdc_sel_e;

  // control word bit positions
  localparam int B_RESET = 15;
  localparam int B_ONAIR = 14;
  localparam int B_ATTN  = 13;
  localparam int B_IEN   = 12;
  localparam int B_PIEN  = 11;
  localparam int B_PERR  = 9;
  localparam int B_INTF  = 8;
  localparam int B_P2    = 5;
  localparam int B_BIG   = 4;

  // parity control bit positions
  localparam int P_ACK  = 8;
  localparam int P_SRC  = 7;
  localparam int P_LANE = 6;

  typedef struct packed {
    logic rst;
    logic onair;
    logic attn;
    logic ien;
    logic pien;
    logic p2;
    logic big;
  } bdc_ctl_t;
endpackage

// File: rtl/bdc_ctl_reg.sv
module bdc_ctl_reg
  import bdc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  bdc_ctl_t wr_val,
  input  logic     irq_in,
  output bdc_ctl_t ctl_q,
  output logic     int_q
);
  bdc_ctl_t ctl_d;
  logic     int_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) ctl_d = wr_val;
    int_d = irq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      int_q <= 1'b0;
    end else begin
      if (wr_en) ctl_q <= ctl_d;
      int_q <= int_d;
    end
  end
endmodule

// File: rtl/bdc_par_cap.sv
module bdc_par_cap #(
  parameter int LO_W = 16,
  parameter int HI_W = 4,
  localparam int AW = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ack,
  input  logic            err_stb,
  input  logic [AW-1:0]   err_addr,
  input  logic            err_src,
  input  logic            err_lane,
  output logic            flag_q,
  output logic [LO_W-1:0] lo_q,
  output logic [HI_W-1:0] hi_q,
  output logic            src_q,
  output logic            lane_q
);
  logic load;
  logic flag_d;
  logic flag_en;

  always_comb begin
    // a new strobe may land when nothing is pending or when the pending one is acknowledged
    load    = err_stb && (!flag_q || ack);
    flag_en = load || ack;
    flag_d  = load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      lo_q   <= '0;
      hi_q   <= '0;
      src_q  <= 1'b0;
      lane_q <= 1'b0;
    end else begin
      if (flag_en) flag_q <= flag_d;
      if (load) begin
        lo_q   <= err_addr[LO_W-1:0];
        hi_q   <= err_addr[AW-1:LO_W];
        src_q  <= err_src;
        lane_q <= err_lane;
      end
    end
  end
endmodule

// File: rtl/bdc_rdmux.sv
module bdc_rdmux
  import bdc_pkg::*;
#(
  parameter int LO_W = 16,
  parameter int HI_W = 4
) (
  input  logic [1:0]        sel,
  input  bdc_ctl_t          ctl,
  input  logic              int_flag,
  input  logic              perr_flag,
  input  logic [HI_W-1:0]   strap,
  input  logic [LO_W-1:0]   cap_lo,
  input  logic [HI_W-1:0]   cap_hi,
  input  logic              cap_src,
  input  logic              cap_lane,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    unique case (bdc_sel_e'(sel))
      SEL_CTRL: begin
        rdata[B_RESET]    = ctl.rst;
        rdata[B_ONAIR]    = ctl.onair;
        rdata[B_ATTN]     = ctl.attn;
        rdata[B_IEN]      = ctl.ien;
        rdata[B_PIEN]     = ctl.pien;
        rdata[B_PERR]     = perr_flag;
        rdata[B_INTF]     = int_flag;
        rdata[B_P2]       = ctl.p2;
        rdata[B_BIG]      = ctl.big;
        rdata[HI_W-1:0]   = strap;
      end
      SEL_PARCTL: begin
        rdata[P_SRC]      = cap_src;
        rdata[P_LANE]     = cap_lane;
        rdata[HI_W-1:0]   = cap_hi;
      end
      SEL_PARLO: rdata[LO_W-1:0] = cap_lo;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/board_ctl_unit.sv
module board_ctl_unit
  import bdc_pkg::*;
#(
  parameter int LO_W = 16,
  parameter int HI_W = 4,
  localparam int AW = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [HI_W-1:0]   base_strap,
  input  logic              ctl_irq,
  input  logic              par_err,
  input  logic [AW-1:0]     par_addr,
  input  logic              par_src,
  input  logic              par_lane,
  output logic              ctl_reset,
  output logic              ctl_attn,
  output logic              on_air,
  output logic              p2_en,
  output logic              ram_256k,
  output logic              host_irq
);
  bdc_ctl_t        wr_val;
  bdc_ctl_t        ctl_q;
  logic            ctl_we;
  logic            ack;
  logic            int_q;
  logic            perr_q;
  logic [LO_W-1:0] cap_lo;
  logic [HI_W-1:0] cap_hi;
  logic            cap_src;
  logic            cap_lane;
  logic            ien_w;
  logic            pien_w;
  logic            unused_wbits;

  always_comb begin
    ctl_we       = reg_we && (bdc_sel_e'(reg_sel) == SEL_CTRL);
    ack          = reg_we && (bdc_sel_e'(reg_sel) == SEL_PARCTL) && reg_wdata[P_ACK];
    wr_val.rst   = reg_wdata[B_RESET];
    wr_val.onair = reg_wdata[B_ONAIR];
    wr_val.attn  = reg_wdata[B_ATTN];
    wr_val.ien   = reg_wdata[B_IEN];
    wr_val.pien  = reg_wdata[B_PIEN];
    wr_val.p2    = reg_wdata[B_P2];
    wr_val.big   = reg_wdata[B_BIG];
    unused_wbits = ^{reg_wdata[10:9], reg_wdata[7:6], reg_wdata[3:0]};
  end

  bdc_ctl_reg u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ctl_we),
    .wr_val (wr_val),
    .irq_in (ctl_irq),
    .ctl_q  (ctl_q),
    .int_q  (int_q)
  );

  bdc_par_cap #(.LO_W(LO_W), .HI_W(HI_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack      (ack),
    .err_stb  (par_err),
    .err_addr (par_addr),
    .err_src  (par_src),
    .err_lane (par_lane),
    .flag_q   (perr_q),
    .lo_q     (cap_lo),
    .hi_q     (cap_hi),
    .src_q    (cap_src),
    .lane_q   (cap_lane)
  );

  bdc_rdmux #(.LO_W(LO_W), .HI_W(HI_W)) u_rd (
    .sel       (reg_sel),
    .ctl       (ctl_q),
    .int_flag  (int_q),
    .perr_flag (perr_q),
    .strap     (base_strap),
    .cap_lo    (cap_lo),
    .cap_hi    (cap_hi),
    .cap_src   (cap_src),
    .cap_lane  (cap_lane),
    .rdata     (reg_rdata)
  );

  always_comb begin
    ien_w     = ctl_q.ien;
    pien_w    = ctl_q.pien;
    ctl_reset = ctl_q.rst;
    ctl_attn  = ctl_q.attn;
    on_air    = ctl_q.onair;
    p2_en     = ctl_q.p2;
    ram_256k  = ctl_q.big;
    host_irq  = (int_q && ien_w) || (perr_q && pien_w);
  end
endmodule

// File: rtl/bdc_checker.sv
module bdc_checker #(
  parameter int LO_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic [1:0]      reg_sel,
  input logic [15:0]     reg_wdata,
  input logic            ctl_irq,
  input logic            par_err,
  input logic            ctl_reset,
  input logic            host_irq,
  input logic            perr_flag,
  input logic            int_flag,
  input logic [LO_W-1:0] cap_lo,
  input logic            ien,
  input logic            pien
);
  logic past_ok;
  logic ack_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  always_comb ack_c = reg_we && (reg_sel == 2'd1) && reg_wdata[8];

  AST_RESET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd0) |=> (ctl_reset == $past(reg_wdata[15]))); // R1

  AST_INT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (int_flag == $past(ctl_irq))); // R4

  AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> perr_flag); // R5

  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_flag && !ack_c) |=> $stable(cap_lo)); // R6

  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_c && !par_err) |=> !perr_flag); // R7

  AST_IRQ_PAR: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_flag && pien) |-> host_irq); // R9

  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien && !pien) |-> !host_irq); // R9
endmodule

bind board_ctl_unit bdc_checker #(.LO_W(LO_W)) u_bdc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .ctl_irq   (ctl_irq),
  .par_err   (par_err),
  .ctl_reset (ctl_reset),
  .host_irq  (host_irq),
  .perr_flag (perr_q),
  .int_flag  (int_q),
  .cap_lo    (cap_lo),
  .ien       (ien_w),
  .pien      (pien_w)
);

// File: tb/test_board_ctl_unit.sv
`timescale 1ns/1ps
module test_board_ctl_unit;
  localparam logic [3:0] STRAP = 4'hA;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        ctl_irq;
  logic        par_err;
  logic [19:0] par_addr;
  logic        par_src;
  logic        par_lane;
  logic        ctl_reset, ctl_attn, on_air, p2_en, ram_256k, host_irq;

  board_ctl_unit i_board_ctl_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .base_strap(STRAP),
    .ctl_irq(ctl_irq), .par_err(par_err), .par_addr(par_addr),
    .par_src(par_src), .par_lane(par_lane), .ctl_reset(ctl_reset),
    .ctl_attn(ctl_attn), .on_air(on_air), .p2_en(p2_en),
    .ram_256k(ram_256k), .host_irq(host_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural model state
  logic [15:0] m_ctl;
  bit          m_int, m_perr, m_src, m_lane;
  logic [15:0] m_lo;
  logic [3:0]  m_hi;

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [1:0] sel);
    case (sel)
      2'd0: exp_rd = m_ctl | (16'(m_perr) << 9) | (16'(m_int) << 8) | 16'(STRAP);
      2'd1: exp_rd = (16'(m_src) << 7) | (16'(m_lane) << 6) | 16'(m_hi);
      2'd2: exp_rd = m_lo;
      default: exp_rd = 16'h0;
    endcase
  endfunction

  task automatic compare_all(input string tag);
    check(tag, "ctl_reset", 16'(ctl_reset), 16'(m_ctl[15]));
    check(tag, "on_air",    16'(on_air),    16'(m_ctl[14]));
    check(tag, "ctl_attn",  16'(ctl_attn),  16'(m_ctl[13]));
    check(tag, "p2_en",     16'(p2_en),     16'(m_ctl[5]));
    check(tag, "ram_256k",  16'(ram_256k),  16'(m_ctl[4]));
    check(tag, "host_irq",  16'(host_irq),
          16'((m_int && m_ctl[12]) || (m_perr && m_ctl[11])));
    check(tag, "reg_rdata", reg_rdata, exp_rd(reg_sel));
  endtask

  task automatic step(input string tag, input bit we, input logic [1:0] sel,
                      input logic [15:0] wd, input bit irq, input bit pe,
                      input logic [19:0] pa, input bit src, input bit lane);
    bit ack;
    @(negedge clk);
    reg_we = we; reg_sel = sel; reg_wdata = wd; ctl_irq = irq;
    par_err = pe; par_addr = pa; par_src = src; par_lane = lane;
    @(posedge clk);
    ack = we && sel == 2'd1 && wd[8];
    m_int = irq;
    if (we && sel == 2'd0) m_ctl = wd & 16'hF830;
    if (pe && (!m_perr || ack)) begin
      m_perr = 1; m_lo = pa[15:0]; m_hi = pa[19:16]; m_src = src; m_lane = lane;
    end else if (ack) m_perr = 0;
    #1;
    compare_all(tag);
  endtask

  // read only: no write, no strobe, irq held
  task automatic rd(input string tag, input logic [1:0] sel, input bit irq);
    step(tag, 0, sel, 16'h0, irq, 0, 20'h0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_ctl = 0; m_int = 0; m_perr = 0; m_src = 0; m_lane = 0; m_lo = 0; m_hi = 0;
    rst_n = 0; reg_we = 0; reg_sel = 0; reg_wdata = 0; ctl_irq = 0;
    par_err = 0; par_addr = 0; par_src = 0; par_lane = 0;
    #12;
    compare_all("R11");   // reset state
    reg_sel = 2'd1; #1; check("R11", "parctl after reset", reg_rdata, 16'h0);
    reg_sel = 2'd2; #1; check("R11", "low addr after reset", reg_rdata, 16'h0);
    reg_sel = 2'd0;
    @(negedge clk); rst_n = 1;
    rd("R11", 2'd0, 0);

    // R1 / R2 / R3: all ones then zeros
    step("R2", 1, 2'd0, 16'hFFFF, 0, 0, 20'h0, 0, 0);
    check("R1", "reset set", 16'(ctl_reset), 16'h1);
    check("R3", "ro bits ignored", reg_rdata, 16'hF83A);
    step("R1", 1, 2'd0, 16'h0000, 0, 0, 20'h0, 0, 0);
    check("R1", "reset released", 16'(ctl_reset), 16'h0);
    step("R3", 1, 2'd0, 16'h07CF, 0, 0, 20'h0, 0, 0);
    check("R3", "only strap", reg_rdata, 16'h000A);
    // attention pulse
    step("R2", 1, 2'd0, 16'h6000, 0, 0, 20'h0, 0, 0);
    check("R2", "attn high", 16'(ctl_attn), 16'h1);
    step("R2", 1, 2'd0, 16'h4000, 0, 0, 20'h0, 0, 0);
    check("R2", "attn low", 16'(ctl_attn), 16'h0);
    step("R2", 1, 2'd0, 16'h0030, 0, 0, 20'h0, 0, 0);

    // R4 / R9 controller interrupt
    rd("R4", 2'd0, 1);
    check("R4", "int flag", reg_rdata & 16'h0100, 16'h0100);
    check("R9", "irq gated off", 16'(host_irq), 16'h0);
    step("R9", 1, 2'd0, 16'h1000, 1, 0, 20'h0, 0, 0);
    check("R9", "irq on", 16'(host_irq), 16'h1);
    rd("R4", 2'd0, 0);
    check("R4", "int flag drop", reg_rdata & 16'h0100, 16'h0000);

    // R5 capture
    step("R5", 1, 2'd0, 16'h0800, 0, 1, 20'h5_1234, 1, 0);
    check("R5", "perr flag", reg_rdata & 16'h0200, 16'h0200);
    check("R9", "parity irq", 16'(host_irq), 16'h1);
    rd("R5", 2'd1, 0);
    check("R5", "parctl", reg_rdata, 16'h0085);
    rd("R5", 2'd2, 0);
    check("R5", "low addr", reg_rdata, 16'h1234);
    // R6 second error ignored
    step("R6", 0, 2'd2, 16'h0, 0, 1, 20'hC_ABCD, 0, 1);
    check("R6", "low addr held", reg_rdata, 16'h1234);
    rd("R6", 2'd1, 0);
    check("R6", "parctl held", reg_rdata, 16'h0085);
    // R7 write without ack bit, then ack
    step("R7", 1, 2'd1, 16'hFEFF, 0, 0, 20'h0, 0, 0);
    check("R7", "no ack no clear", reg_rdata, 16'h0085);
    step("R7", 1, 2'd1, 16'h0100, 0, 0, 20'h0, 0, 0);
    check("R7", "ack reads zero", reg_rdata & 16'h0100, 16'h0);
    rd("R7", 2'd0, 0);
    check("R7", "flag cleared", reg_rdata & 16'h0200, 16'h0);
    // R8 collision
    step("R8", 0, 2'd0, 16'h0, 0, 1, 20'h3_0F0F, 0, 1);
    step("R8", 1, 2'd1, 16'h0100, 0, 1, 20'h9_7777, 1, 1);
    check("R8", "new capture", reg_rdata, 16'h00C9);
    rd("R8", 2'd0, 0);
    check("R8", "flag kept", reg_rdata & 16'h0200, 16'h0200);
    // R10 writes to 2 and 3 ignored
    step("R10", 1, 2'd2, 16'hFFFF, 0, 0, 20'h0, 0, 0);
    check("R10", "low addr ro", reg_rdata, 16'h7777);
    step("R10", 1, 2'd3, 16'hFFFF, 0, 0, 20'h0, 0, 0);
    check("R10", "sel3 zero", reg_rdata, 16'h0);
    step("R10", 1, 2'd1, 16'h0100, 0, 0, 20'h0, 0, 0);

    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step("R10", r[0] & r[1], r[3:2], 16'($urandom), r[4], r[5] & r[6],
           20'($urandom), r[7], r[8]);
    end
    finish_run();
  end
endmodule